// File: doc/BRIEF.md
# Serial EEPROM Target Over I2C

This block is an I2C target that serves a byte-addressed storage array of 256 bytes. It runs on a system clock that oversamples the bus. SCL and SDA each pass through a two-flop synchronizer. The block pulls SDA low through an output-enable, and the pad forms the open-drain wired-AND. The target responds when the select byte carries the fixed prefix binary 1010 followed by the three select pins. A write select is followed by one address byte and then data bytes. The data bytes collect in a 16-byte page buffer.

The page buffer reaches the array only when the master ends the transfer with STOP directly after the acknowledge of a data byte. The target then stays busy for a parameter number of clocks and ignores the bus for that time. A master can therefore poll with write selects until one is acknowledged. Reads start either from the current address counter or from an address loaded by a write select and an address byte followed by a repeated START. Reads continue for as long as the master acknowledges.

Top module: `i2c_ee_target`

## Requirements
- R1: After reset every array byte reads FFh, SDA is released (sda_oe_o = 0) and the target is deselected.
- R2: A select byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal sel_pins_i. Bit 0 is the direction, where 1 means read. On a mismatch the target drives nothing until the next START.
- R3: A write select, then an address byte, then one data byte, then STOP stores the data byte at that address.
- R4: A page write stores each data byte at the next location. Only address bits 3..0 advance, and they wrap inside the 16-byte page. When more than 16 bytes are sent, later bytes overwrite earlier ones.
- R5: A STOP that does not follow a data-byte acknowledge directly, such as one in the middle of a byte, and a repeated START after data both leave the array unchanged and start no busy period.
- R6: While wp_i is high, data bytes get NACK, the array is unchanged and no busy period starts.
- R7: For WRITE_CYCLES clocks after a committing STOP, the target acknowledges nothing, including its own select byte. After that it acknowledges again.
- R8: After a commit, the address counter points to the byte after the last byte written, wrapping inside the page.
- R9: A random read returns the byte at the loaded address. Each master ACK sends the next byte, with the full 8-bit address wrapping from FFh to 00h.
- R10: A read select with no address phase starts at the address counter. The counter advances once for each byte sent, including the byte the master answers with NACK.
- R11: sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low |
| wp_i | input | 1 | Write protect; high blocks data writes |
| sel_pins_i | input | 3 | Select bits that the select byte must match |

## Verification
A wrong address counter shows up within one byte time as a wrong first byte on the next current-address read. A wrong page-buffer index appears only after the commit, when the page is read back, so every page test reads back all 16 locations. A missing or wrong busy state shows at the first polling select after STOP: it is acknowledged too early or never. An armed flag that is not cleared shows as a commit after an aborted write, and a read-back then returns something other than FFh.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {PH_DEV, PH_ADDR, PH_DATA} ph_e;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_ee_bus_sync.sv
module i2c_ee_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NLINE = 2;  // [0] scl, [1] sda
  logic [NLINE-1:0] pad, s1_q, s2_q, s3_q;
  assign pad = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b1;
        s2_q[g] <= 1'b1;
        s3_q[g] <= 1'b1;
      end else begin
        s1_q[g] <= pad[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
  end

  assign scl_o      = s2_q[0];
  assign sda_o      = s2_q[1];
  assign scl_rise_o = s2_q[0] & ~s3_q[0];
  assign scl_fall_o = ~s2_q[0] & s3_q[0];
  assign start_o    = s2_q[0] & s3_q[0] & s3_q[1] & ~s2_q[1];
  assign stop_o     = s2_q[0] & s3_q[0] & ~s3_q[1] & s2_q[1];
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PAGE  = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [$clog2(DEPTH)-1:0]           rd_addr_i,
  output logic [7:0]                         rd_data_o,
  input  logic                               buf_we_i,
  input  logic [$clog2(PAGE)-1:0]            buf_idx_i,
  input  logic [7:0]                         buf_data_i,
  input  logic                               buf_clr_i,
  input  logic                               commit_i,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_i
);
  localparam int unsigned PW = $clog2(PAGE);

  logic [7:0]      mem_q [DEPTH];
  logic [7:0]      buf_q [PAGE];
  logic [PAGE-1:0] mask_q;

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE; i++)
        if (mask_q[i]) mem_q[{page_i, PW'(i)}] <= buf_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= 8'h00;
    end else if (commit_i || buf_clr_i) begin
      mask_q <= '0;
    end else if (buf_we_i) begin
      buf_q[buf_idx_i]  <= buf_data_i;
      mask_q[buf_idx_i] <= 1'b1;
    end
  end

  // R3: a commit always carries at least one latched byte
  a_r3_commit_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (mask_q != '0));
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target import i2c_ee_pkg::*; #(
  parameter int unsigned DEPTH        = 256,
  parameter int unsigned PAGE         = 16,
  parameter int unsigned WRITE_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       wp_i,
  input  logic [2:0] sel_pins_i
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = $clog2(PAGE);
  localparam int unsigned BW = $clog2(WRITE_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  st_q;
  ph_e  ph_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q, tx_q, rd_data;
  logic [AW-1:0] addr_q, rd_addr;
  logic          rd_q, wdata_q, armed_q, mack_q, oe_q;
  logic [BW-1:0] busy_q;
  logic          busy, dec, sel_hit, buf_we, buf_clr, commit;

  i2c_ee_bus_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  always_comb begin
    busy    = busy_q != '0;
    dec     = !busy && st_q == ST_RX && scl_fall && cnt_q == 4'd8;
    sel_hit = sh_q[7:1] == {DEV_PREFIX, sel_pins_i};
    buf_we  = dec && ph_q == PH_DATA && !wp_i;
    commit  = !busy && stop_det && armed_q;
    buf_clr = !busy && (start_det || (stop_det && !armed_q) || (dec && ph_q == PH_ADDR));
    rd_addr = (st_q == ST_MACK) ? addr_q + AW'(1) : addr_q;
  end

  i2c_ee_store #(.DEPTH(DEPTH), .PAGE(PAGE)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .buf_we_i(buf_we), .buf_idx_i(addr_q[PW-1:0]), .buf_data_i(sh_q),
    .buf_clr_i(buf_clr), .commit_i(commit), .page_i(addr_q[AW-1:PW])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ph_q <= PH_DEV; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      addr_q <= '0; rd_q <= 1'b0; wdata_q <= 1'b0; armed_q <= 1'b0;
      mack_q <= 1'b0; oe_q <= 1'b0; busy_q <= '0;
    end else if (busy) begin
      busy_q <= busy_q - BW'(1);
      st_q <= ST_IDLE; oe_q <= 1'b0; armed_q <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_RX; ph_q <= PH_DEV; cnt_q <= '0; rd_q <= 1'b0;
      oe_q <= 1'b0; armed_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE; oe_q <= 1'b0; armed_q <= 1'b0;
      if (armed_q) busy_q <= BW'(WRITE_CYCLES);
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end
          if (scl_fall) begin
            if (cnt_q != 4'd8) armed_q <= 1'b0;  // a bit went by: no longer in the 10th slot
            else begin
              cnt_q   <= '0;
              wdata_q <= 1'b0;
              unique case (ph_q)
                PH_DEV: begin
                  if (sel_hit) begin
                    oe_q <= 1'b1; st_q <= ST_ACK; rd_q <= sh_q[0];
                    if (!sh_q[0]) ph_q <= PH_ADDR;
                  end else st_q <= ST_IDLE;
                end
                PH_ADDR: begin
                  oe_q <= 1'b1; st_q <= ST_ACK;
                  addr_q <= sh_q[AW-1:0]; ph_q <= PH_DATA;
                end
                PH_DATA: begin
                  if (wp_i) st_q <= ST_IDLE;
                  else begin
                    oe_q <= 1'b1; st_q <= ST_ACK; wdata_q <= 1'b1;
                    addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
                  end
                end
                default: st_q <= ST_IDLE;
              endcase
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (rd_q) begin
            tx_q <= rd_data; oe_q <= ~rd_data[7]; st_q <= ST_TX;
          end else begin
            oe_q <= 1'b0; st_q <= ST_RX; armed_q <= wdata_q;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            oe_q <= 1'b0; st_q <= ST_MACK;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0}; oe_q <= ~tx_q[6]; cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            addr_q <= addr_q + AW'(1);
            if (mack_q) begin
              tx_q <= rd_data; oe_q <= ~rd_data[7]; st_q <= ST_TX; cnt_q <= '0;
            end else st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  a_r11_oe_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  a_r7_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  a_r5_busy_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));

  a_r4_page_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]))
            && (addr_q[PW-1:0] == $past(addr_q[PW-1:0]) + PW'(1)));
endmodule

// File: tb/i2c_ee_target_tb.sv
module i2c_ee_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] SEL_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b101;
  logic oe;
  wire  sda_line = sda_m & ~oe;

  int nchk = 0, nerr = 0, viol = 0, scl_hi = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf [20];
  logic [7:0] rbuf [20];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ee_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(oe), .wp_i(wp), .sel_pins_i(pins)
  );

  // R11 monitor: SDA drive must not move while SCL has been high for a while
  always @(negedge clk) begin
    scl_hi = scl ? scl_hi + 1 : 0;
    if (oe !== prev_oe && scl_hi > 3) viol++;
    prev_oe = oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input int n);
    logic ok, ak;
    bus_start(); send_byte(SEL_W, ok); send_byte(a, ak); ok &= ak;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ak);
      if (ok && ak) model[{a[7:4], 4'(a[3:0] + 4'(k))}] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic poll(output int tries, output logic first_ack);
    logic ak;
    tries = 0;
    do begin
      bus_start(); send_byte(SEL_W, ak); bus_stop();
      if (tries == 0) first_ack = ak;
      tries++;
    end while (!ak && tries < 50);
  endtask

  task automatic rd_random(input logic [7:0] a, input int n);
    logic ak;
    bus_start(); send_byte(SEL_W, ak); send_byte(a, ak);
    bus_start(); send_byte(SEL_R, ak);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    bus_stop();
  endtask

  task automatic rd_current(input int n);
    logic ak;
    bus_start(); send_byte(SEL_R, ak);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    bus_stop();
  endtask

  initial begin
    int tries;
    logic fa, ak;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(5);

    chk("R1 oe after reset", oe, 0);
    rd_random(8'h00, 1); chk("R1 byte 00", rbuf[0], 8'hFF);
    rd_random(8'h80, 1); chk("R1 byte 80", rbuf[0], 8'hFF);

    // R2: wrong select pins, wrong prefix, then a byte with no START
    bus_start(); send_byte(8'hA2, ak); chk("R2 pin mismatch", ak, 0);
    send_byte(SEL_W, ak); chk("R2 silent until START", ak, 0); bus_stop();
    bus_start(); send_byte(8'hBA, ak); chk("R2 prefix mismatch", ak, 0); bus_stop();
    bus_start(); send_byte(SEL_W, ak); chk("R2 match ack", ak, 1); bus_stop();

    // R3 + R7 byte write then polling
    wbuf[0] = 8'hA5; do_write(8'h10, 1);
    poll(tries, fa);
    chk("R7 first poll nack", fa, 0);
    chk("R7 poll ends with ack", (tries > 1 && tries < 50), 1);
    rd_random(8'h10, 1); chk("R3 byte write", rbuf[0], 8'hA5);

    // R8 counter after commit
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h31 + 8'(k);
    do_write(8'h30, 4); poll(tries, fa);
    wbuf[0] = 8'h77; do_write(8'h30, 1); poll(tries, fa);
    rd_current(1); chk("R8 next after write", rbuf[0], model[8'h31]);

    // R4 full page with wrap from 4A, then 18-byte overflow at 50
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(k * 3 + 1);
    do_write(8'h4A, 16); poll(tries, fa);
    rd_random(8'h40, 16);
    for (int k = 0; k < 16; k++) chk("R4 page wrap", rbuf[k], model[8'h40 + k]);
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'hC0 ^ k);
    do_write(8'h50, 18); poll(tries, fa);
    rd_random(8'h50, 16);
    for (int k = 0; k < 16; k++) chk("R4 overflow", rbuf[k], model[8'h50 + k]);
    chk("R4 later wins", model[8'h50], 8'hC0 ^ 8'd16);

    // R6 write protect
    wp = 1'b1;
    bus_start(); send_byte(SEL_W, ak); send_byte(8'h60, ak);
    send_byte(8'h11, ak); chk("R6 data nack", ak, 0); bus_stop();
    wp = 1'b0;
    poll(tries, fa); chk("R6 no busy", fa, 1);
    rd_random(8'h60, 1); chk("R6 unchanged", rbuf[0], 8'hFF);

    // R5 aborted writes: STOP mid-byte, repeated START after data
    bus_start(); send_byte(SEL_W, ak); send_byte(8'h70, ak);
    send_byte(8'h12, ak); send_bits(8'hF0, 4); bus_stop();
    poll(tries, fa); chk("R5 mid-byte stop no busy", fa, 1);
    rd_random(8'h70, 1); chk("R5 mid-byte stop unchanged", rbuf[0], 8'hFF);
    bus_start(); send_byte(SEL_W, ak); send_byte(8'h71, ak); send_byte(8'h34, ak);
    bus_start(); send_byte(SEL_W, ak); bus_stop();
    poll(tries, fa); chk("R5 restart no busy", fa, 1);
    rd_random(8'h71, 1); chk("R5 restart unchanged", rbuf[0], 8'hFF);

    // R9 wrap FF->00, R10 current address after NACKed byte
    wbuf[0] = 8'h5A; do_write(8'hFF, 1); poll(tries, fa);
    wbuf[0] = 8'hC3; wbuf[1] = 8'h11; wbuf[2] = 8'h9E; do_write(8'h00, 3); poll(tries, fa);
    rd_random(8'hFF, 2);
    chk("R9 byte FF", rbuf[0], 8'h5A);
    chk("R9 wrap to 00", rbuf[1], 8'hC3);
    rd_current(2);
    chk("R10 current 01", rbuf[0], 8'h11);
    chk("R10 current 02", rbuf[1], 8'h9E);

    chk("R11 oe moved with SCL high", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule